// File: doc/BRIEF.md
# Masked Content-Addressable Match Array

This block is a small content-addressable memory. Each entry is a 64-bit word with one validity bit. A comparand register holds the search key, and seven 64-bit mask registers can hide selected bit positions. A compare cycle checks the comparand against every valid entry at once. The block then reports three things: an active-low match flag, an active-low multiple-match flag, and the address of the lowest-numbered matching entry.

Write cycles put data into one entry. The entry is chosen either by an explicit address or by an internal address pointer, and the pointer can step up or down automatically after each access. A mask register can protect bits during a write. The block also reports a full flag, the lowest-numbered empty entry, and a 32-bit status word that gathers the flags, the kind of the last result, a page number and the active address.

All commands are synchronous, one per clock. Every registered result appears one cycle after the command that produced it.

Top module: `mcam_core`

## Requirements
- R1: After reset, every entry is empty and its stored data is zero. The pointer is 0, the active address is 0 and the result type is 2'b00. `match_n_o` and `mmatch_n_o` are high, and `next_free_o` is 0.
- R2: COMPARE (cmd 3) tests the comparand against valid entries only. With `mask_sel_i` = k in 1..7, bit positions where mask register k holds 1 are excluded from the compare. With k = 0, all bits take part. LOAD_CMP (cmd 1) loads the comparand. LOAD_MASK (cmd 2) loads mask register k from `data_i`.
- R3: WRITE (cmd 4 direct at `addr_i`, cmd 5/6 at the pointer) leaves each bit unchanged where the selected mask holds 1 and stores `data_i` elsewhere. With `mask_sel_i` = 0, all bits are written. Every write marks the entry valid.
- R4: One cycle after COMPARE, `match_n_o` is low if any valid entry matched, and `mmatch_n_o` is low if two or more matched. Both flags hold until the next compare or memory access.
- R5: After COMPARE, the active address is the lowest matching address, or 0 when nothing matched, and the result type is 2'b01.
- R6: `full_n_o` is low only when every entry is valid and `fi_n_i` is low. It follows these inputs combinationally.
- R7: `next_free_o` is the lowest-numbered empty entry. It is 0 when no entry is empty.
- R8: The pointer responds to PTR_LOAD (cmd 11, from `addr_i`), PTR_INC (cmd 9) and PTR_DEC (cmd 10). It wraps modulo DEPTH. Writes 5/6 and reads 7/8 use the pointer and then increment it (5, 7) or decrement it (6, 8). A read registers the entry into `read_data_o`.
- R9: The status word is laid out as follows: bit 30 match flag, bit 29 multiple-match flag, bit 28 full flag, bits 25:24 result type, bits 19:16 `page_i`, bits 11:0 active address. All other bits are 0.
- R10: A read or write (cmds 4 to 8) sets the result type to 2'b10, sets the active address to the accessed entry, and raises both match flags.
- R11: SET_EMPTY (cmd 12) marks entry `addr_i` empty, so later compares skip it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 4 | Command code (0 = idle) |
| data_i | input | WIDTH | Write, comparand or mask data |
| addr_i | input | AW | Direct entry address or pointer load value |
| mask_sel_i | input | 3 | Mask register select, 0 = unmasked |
| fi_n_i | input | 1 | Active-low full input from a neighbour |
| page_i | input | 4 | Page number placed into status |
| match_n_o | output | 1 | Active-low match flag |
| mmatch_n_o | output | 1 | Active-low multiple-match flag |
| full_n_o | output | 1 | Active-low full flag |
| active_addr_o | output | AW | Match or accessed address |
| next_free_o | output | AW | Lowest empty entry |
| ptr_o | output | AW | Address pointer |
| read_data_o | output | WIDTH | Last read entry |
| status_o | output | 32 | Status word |

## Verification
The embedded assertions check on every cycle that:
- a multiple match never appears without a match;
- the full flag never asserts while `fi_n_i` is high or while an entry is empty;
- the next-free address always names an empty entry;
- pointer increments and decrements wrap correctly;
- a compare always leaves the match result type.

Other behaviour depends on chosen data and can only be shown by the directed scenarios. This covers lowest-address priority among several hits, and how bits are excluded by a mask during a compare versus preserved by a mask during a write. It also covers invalidated entries dropping out of compares and the exact bit positions of the status word.

// File: rtl/mcam_pkg.sv
package mcam_pkg;
   typedef enum logic [3:0] {
      CMD_IDLE     = 4'd0,
      CMD_LD_CMP   = 4'd1,
      CMD_LD_MASK  = 4'd2,
      CMD_COMPARE  = 4'd3,
      CMD_WR_DIR   = 4'd4,
      CMD_WR_INC   = 4'd5,
      CMD_WR_DEC   = 4'd6,
      CMD_RD_INC   = 4'd7,
      CMD_RD_DEC   = 4'd8,
      CMD_PTR_INC  = 4'd9,
      CMD_PTR_DEC  = 4'd10,
      CMD_PTR_LOAD = 4'd11,
      CMD_SET_EMPT = 4'd12
   } mcam_cmd_e;

   typedef enum logic [1:0] {
      RES_RESET  = 2'b00,
      RES_MATCH  = 2'b01,
      RES_ACCESS = 2'b10
   } mcam_res_e;
endpackage

// File: rtl/mcam_prienc.sv
module mcam_prienc #(
   parameter int N  = 16,
   parameter int AW = 4
) (
   input  logic [N-1:0]  vec_i,
   output logic          found_o,
   output logic [AW-1:0] idx_o,
   output logic          multi_o
);
   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = AW'(i);
      end
   end
   assign found_o = |vec_i;
   assign multi_o = |(vec_i & (vec_i - N'(1)));
endmodule

// File: rtl/mcam_ptr.sv
module mcam_ptr #(
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] load_val_i,
   input  logic          inc_i,
   input  logic          dec_i,
   output logic [AW-1:0] ptr_o
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   logic [AW-1:0] up, down;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign up   = ptr_o + AW'(1);
         assign down = ptr_o - AW'(1);
      end else begin : g_any
         assign up   = (ptr_o == LAST) ? '0 : ptr_o + AW'(1);
         assign down = (ptr_o == '0) ? LAST : ptr_o - AW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr_o <= '0;
      else if (load_i) ptr_o <= load_val_i;
      else if (inc_i)  ptr_o <= up;
      else if (dec_i)  ptr_o <= down;
   end

   assert_ptr_inc_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i) |=> ptr_o == (($past(ptr_o) == LAST) ? '0 : $past(ptr_o) + AW'(1)));
   assert_ptr_dec_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !inc_i && !load_i) |=> ptr_o == (($past(ptr_o) == '0) ? LAST : $past(ptr_o) - AW'(1)));
endmodule

// File: rtl/mcam_array.sv
module mcam_array #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 64,
   parameter int AW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en_i,
   input  logic [AW-1:0]    wr_addr_i,
   input  logic [WIDTH-1:0] wr_data_i,
   input  logic [WIDTH-1:0] wr_keep_i,
   input  logic             clr_en_i,
   input  logic [AW-1:0]    clr_addr_i,
   input  logic [WIDTH-1:0] key_i,
   input  logic [WIDTH-1:0] ignore_i,
   input  logic [AW-1:0]    rd_addr_i,
   output logic [WIDTH-1:0] rd_data_o,
   output logic [DEPTH-1:0] hit_o,
   output logic [DEPTH-1:0] valid_o
);
   logic [WIDTH-1:0] store_q [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               store_q[e] <= '0;
               valid_o[e] <= 1'b0;
            end else if (wr_en_i && wr_addr_i == AW'(e)) begin
               store_q[e] <= (store_q[e] & wr_keep_i) | (wr_data_i & ~wr_keep_i);
               valid_o[e] <= 1'b1;
            end else if (clr_en_i && clr_addr_i == AW'(e)) begin
               valid_o[e] <= 1'b0;
            end
         end
         assign hit_o[e] = valid_o[e] && (((store_q[e] ^ key_i) & ~ignore_i) == '0);
      end
   endgenerate

   assign rd_data_o = store_q[rd_addr_i];
endmodule

// File: rtl/mcam_core.sv
module mcam_core
   import mcam_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int WIDTH = 64,
   parameter int NMASK = 7,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       cmd_i,
   input  logic [WIDTH-1:0] data_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [2:0]       mask_sel_i,
   input  logic             fi_n_i,
   input  logic [3:0]       page_i,
   output logic             match_n_o,
   output logic             mmatch_n_o,
   output logic             full_n_o,
   output logic [AW-1:0]    active_addr_o,
   output logic [AW-1:0]    next_free_o,
   output logic [AW-1:0]    ptr_o,
   output logic [WIDTH-1:0] read_data_o,
   output logic [31:0]      status_o
);
   initial begin
      if (DEPTH < 2 || AW > 12) $error("mcam_core: DEPTH must be 2..4096");
      if (NMASK < 1 || NMASK > 7) $error("mcam_core: NMASK must be 1..7");
   end

   mcam_cmd_e        cmd;
   logic [WIDTH-1:0] cmp_q;
   logic [WIDTH-1:0] mask_q [NMASK];
   logic [WIDTH-1:0] sel_mask;
   logic [DEPTH-1:0] hit_vec, valid_vec;
   logic [WIDTH-1:0] rd_data;
   logic             hit_found, hit_multi, free_found, free_multi;
   logic [AW-1:0]    hit_idx, acc_addr;
   logic             is_wr, is_rd, is_acc;
   mcam_res_e        rtype_q;

   assign cmd = mcam_cmd_e'(cmd_i);
   assign is_wr  = (cmd == CMD_WR_DIR) || (cmd == CMD_WR_INC) || (cmd == CMD_WR_DEC);
   assign is_rd  = (cmd == CMD_RD_INC) || (cmd == CMD_RD_DEC);
   assign is_acc = is_wr || is_rd;
   assign acc_addr = (cmd == CMD_WR_DIR) ? addr_i : ptr_o;

   always_comb begin
      sel_mask = '0;
      for (int k = 1; k <= NMASK; k++) begin
         if (mask_sel_i == 3'(k)) sel_mask = mask_q[k-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
         for (int k = 0; k < NMASK; k++) mask_q[k] <= '0;
      end else if (cmd == CMD_LD_CMP) begin
         cmp_q <= data_i;
      end else if (cmd == CMD_LD_MASK) begin
         for (int k = 1; k <= NMASK; k++) begin
            if (mask_sel_i == 3'(k)) mask_q[k-1] <= data_i;
         end
      end
   end

   mcam_array #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) array_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(is_wr), .wr_addr_i(acc_addr), .wr_data_i(data_i), .wr_keep_i(sel_mask),
      .clr_en_i(cmd == CMD_SET_EMPT), .clr_addr_i(addr_i),
      .key_i(cmp_q), .ignore_i(sel_mask),
      .rd_addr_i(ptr_o), .rd_data_o(rd_data),
      .hit_o(hit_vec), .valid_o(valid_vec)
   );

   mcam_prienc #(.N(DEPTH), .AW(AW)) hit_enc_i (
      .vec_i(hit_vec), .found_o(hit_found), .idx_o(hit_idx), .multi_o(hit_multi)
   );

   mcam_prienc #(.N(DEPTH), .AW(AW)) free_enc_i (
      .vec_i(~valid_vec), .found_o(free_found), .idx_o(next_free_o), .multi_o(free_multi)
   );

   mcam_ptr #(.DEPTH(DEPTH), .AW(AW)) ptr_i (
      .clk(clk), .rst_n(rst_n),
      .load_i(cmd == CMD_PTR_LOAD), .load_val_i(addr_i),
      .inc_i(cmd == CMD_PTR_INC || cmd == CMD_WR_INC || cmd == CMD_RD_INC),
      .dec_i(cmd == CMD_PTR_DEC || cmd == CMD_WR_DEC || cmd == CMD_RD_DEC),
      .ptr_o(ptr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_n_o     <= 1'b1;
         mmatch_n_o    <= 1'b1;
         active_addr_o <= '0;
         rtype_q       <= RES_RESET;
         read_data_o   <= '0;
      end else if (cmd == CMD_COMPARE) begin
         match_n_o     <= ~hit_found;
         mmatch_n_o    <= ~hit_multi;
         active_addr_o <= hit_idx;
         rtype_q       <= RES_MATCH;
      end else if (is_acc) begin
         match_n_o     <= 1'b1;
         mmatch_n_o    <= 1'b1;
         active_addr_o <= acc_addr;
         rtype_q       <= RES_ACCESS;
         if (is_rd) read_data_o <= rd_data;
      end
   end

   assign full_n_o = ~(~free_found & ~fi_n_i);

   assign status_o = {1'b0, match_n_o, mmatch_n_o, full_n_o, 2'b00, rtype_q,
                      4'b0000, page_i, 4'b0000, 12'(active_addr_o)};

   assert_multi_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mmatch_n_o |-> !match_n_o);
   assert_full_needs_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !full_n_o |-> (!fi_n_i && (&valid_vec)));
   assert_free_is_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (free_found || free_multi) |-> !valid_vec[next_free_o]);
   assert_compare_type_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_COMPARE) |=> (rtype_q == RES_MATCH));
   assert_access_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      is_acc |=> (match_n_o && mmatch_n_o && rtype_q == RES_ACCESS));
endmodule

// File: tb/mcam_core_tb.sv
`timescale 1ns/1ps
module mcam_core_tb_top;
   localparam int DEPTH = 16;
   localparam int WIDTH = 64;
   localparam int AW    = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [3:0]       cmd_i = '0;
   logic [WIDTH-1:0] data_i = '0;
   logic [AW-1:0]    addr_i = '0;
   logic [2:0]       mask_sel_i = '0;
   logic             fi_n_i = 1'b1;
   logic [3:0]       page_i = 4'hA;
   logic             match_n_o, mmatch_n_o, full_n_o;
   logic [AW-1:0]    active_addr_o, next_free_o, ptr_o;
   logic [WIDTH-1:0] read_data_o;
   logic [31:0]      status_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 0;

   localparam logic [63:0] VA = 64'h1111_2222_3333_4444;
   localparam logic [63:0] VB = 64'hDEAD_BEEF_0000_0001;
   localparam logic [63:0] VC = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] VD = 64'hAAAA_BBBB_CCCC_DDDD;

   always #2 clk = ~clk;

   mcam_core #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .data_i(data_i), .addr_i(addr_i),
      .mask_sel_i(mask_sel_i), .fi_n_i(fi_n_i), .page_i(page_i),
      .match_n_o(match_n_o), .mmatch_n_o(mmatch_n_o), .full_n_o(full_n_o),
      .active_addr_o(active_addr_o), .next_free_o(next_free_o), .ptr_o(ptr_o),
      .read_data_o(read_data_o), .status_o(status_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic run(input logic [3:0] c, input logic [63:0] d, input logic [3:0] a,
                      input logic [2:0] s);
      @(negedge clk);
      cmd_i = c; data_i = d; addr_i = a; mask_sel_i = s;
      @(negedge clk);
      cmd_i = 4'd0;
   endtask

   task automatic t_reset;
      check("R1 match_n", 64'(match_n_o), 64'd1);
      check("R1 mmatch_n", 64'(mmatch_n_o), 64'd1);
      check("R1 next_free", 64'(next_free_o), 64'd0);
      check("R1 ptr", 64'(ptr_o), 64'd0);
      check("R1 R9 status", 64'(status_o), 64'h700A_0000);
   endtask

   task automatic t_basic_compare;
      run(4'd4, VA, 4'd3, 3'd0);
      run(4'd4, VB, 4'd5, 3'd0);
      check("R10 status after write", 64'(status_o), 64'h720A_0005);
      run(4'd1, VB, 4'd0, 3'd0);
      run(4'd3, 64'd0, 4'd0, 3'd0);
      check("R4 single match_n", 64'(match_n_o), 64'd0);
      check("R4 single mmatch_n", 64'(mmatch_n_o), 64'd1);
      check("R5 active", 64'(active_addr_o), 64'd5);
      check("R9 status after compare", 64'(status_o), 64'h310A_0005);
      run(4'd1, VC, 4'd0, 3'd0);
      run(4'd3, 64'd0, 4'd0, 3'd0);
      check("R4 no match_n", 64'(match_n_o), 64'd1);
      check("R5 no-match active", 64'(active_addr_o), 64'd0);
   endtask

   task automatic t_masked_compare;
      run(4'd2, 64'h0000_0000_FFFF_FFFF, 4'd0, 3'd1);
      run(4'd1, 64'hDEAD_BEEF_FFFF_FFFF, 4'd0, 3'd0);
      run(4'd3, 64'd0, 4'd0, 3'd1);
      check("R2 masked hit", 64'(match_n_o), 64'd0);
      check("R2 masked addr", 64'(active_addr_o), 64'd5);
      run(4'd3, 64'd0, 4'd0, 3'd0);
      check("R2 unmasked miss", 64'(match_n_o), 64'd1);
   endtask

   task automatic t_priority;
      run(4'd4, VB, 4'd9, 3'd0);
      run(4'd4, VB, 4'd12, 3'd0);
      run(4'd1, VB, 4'd0, 3'd0);
      run(4'd3, 64'd0, 4'd0, 3'd0);
      check("R5 lowest of three", 64'(active_addr_o), 64'd5);
      check("R4 multi", 64'(mmatch_n_o), 64'd0);
      run(4'd12, 64'd0, 4'd5, 3'd0);
      run(4'd3, 64'd0, 4'd0, 3'd0);
      check("R11 skip emptied", 64'(active_addr_o), 64'd9);
      check("R4 multi of two", 64'(mmatch_n_o), 64'd0);
      run(4'd12, 64'd0, 4'd9, 3'd0);
      run(4'd3, 64'd0, 4'd0, 3'd0);
      check("R11 last one", 64'(active_addr_o), 64'd12);
      check("R4 single after clear", 64'(mmatch_n_o), 64'd1);
      check("R4 match kept", 64'(match_n_o), 64'd0);
   endtask

   task automatic t_masked_write;
      run(4'd2, 64'hFFFF_0000_0000_0000, 4'd0, 3'd2);
      run(4'd4, VD, 4'd3, 3'd2);
      run(4'd11, 64'd0, 4'd3, 3'd0);
      run(4'd7, 64'd0, 4'd0, 3'd0);
      check("R3 masked write", read_data_o, 64'h1111_BBBB_CCCC_DDDD);
      check("R8 read inc ptr", 64'(ptr_o), 64'd4);
   endtask

   task automatic t_next_free;
      check("R7 first free", 64'(next_free_o), 64'd0);
      run(4'd4, VC, 4'd0, 3'd0);
      check("R7 after fill 0", 64'(next_free_o), 64'd1);
   endtask

   task automatic t_full;
      run(4'd11, 64'd0, 4'd0, 3'd0);
      for (int i = 0; i < DEPTH; i++) run(4'd5, 64'h5000_0000_0000_0000 | 64'(i), 4'd0, 3'd0);
      check("R8 wrap after fill", 64'(ptr_o), 64'd0);
      check("R7 none free", 64'(next_free_o), 64'd0);
      check("R6 fi high", 64'(full_n_o), 64'd1);
      @(negedge clk); fi_n_i = 1'b0; #1;
      check("R6 full", 64'(full_n_o), 64'd0);
      @(negedge clk); fi_n_i = 1'b1;
      run(4'd1, 64'h5000_0000_0000_0007, 4'd0, 3'd0);
      run(4'd3, 64'd0, 4'd0, 3'd0);
      check("R5 unique hit", 64'(active_addr_o), 64'd7);
      check("R4 unique multi", 64'(mmatch_n_o), 64'd1);
      run(4'd12, 64'd0, 4'd6, 3'd0);
      check("R6 not full after clear", 64'(full_n_o), 64'd1);
      check("R7 freed entry", 64'(next_free_o), 64'd6);
   endtask

   task automatic t_pointer;
      run(4'd10, 64'd0, 4'd0, 3'd0);
      check("R8 dec wrap", 64'(ptr_o), 64'd15);
      run(4'd9, 64'd0, 4'd0, 3'd0);
      check("R8 inc wrap", 64'(ptr_o), 64'd0);
      run(4'd8, 64'd0, 4'd0, 3'd0);
      check("R8 read dec data", read_data_o, 64'h5000_0000_0000_0000);
      check("R8 read dec ptr", 64'(ptr_o), 64'd15);
      check("R10 status after read", 64'(status_o), 64'h720A_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic_compare();
      t_masked_compare();
      t_priority();
      t_masked_write();
      t_next_free();
      t_full();
      t_pointer();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end
endmodule